// File: doc/BRIEF.md
# Double-Banked Slot Schedule Sequencer

This block steps a network adapter through its time-division slot schedule and lets the schedule change while the system runs. A cycle counter divides the local clock into slots of three cycles each. A slot index walks through the active schedule and returns to zero after the last slot. A one-hot period register rotates by one position at every wrap. The slot table has two banks. The active bank drives the slot outputs. The other bank is idle and takes writes while the current schedule keeps running.

A swap request arrives from another timing area as a level that toggles once per request. A target period travels with it as bundled data. The toggle passes through a flip-flop synchronizer. Either edge of the synchronized toggle captures the target and arms the swap. The swap happens at the end of the period whose one-hot code equals the target. At that edge the active bank flips, and the slot index starts wrapping at the length that was loaded beforehand through the length input. Every agent that uses the same target therefore changes schedule on the same period boundary.

Top module: `slot_swap_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released: `activeBank` is 0, `curSlot` is 0, `slotStart` is 1, and every table entry reads as invalid with pointer 0 and delay 0. The reset schedule length is SLOTS and the period register holds bit 0.
- R2: `slotStart` is high for exactly one cycle in every CYC_PER_SLOT (3) cycles. It is high in the first cycle of each slot.
- R3: `curSlot` advances by one at each slot boundary. After the current last slot it returns to 0.
- R4: `slotValid`, `slotPtr` and `slotDelay` always show the entry of the active bank at index `curSlot`. `slotDelay` is a 2-bit postpone count in clock cycles, with allowed values 0, 1 and 2, and is returned as written.
- R5: A write with `wrEn` high stores `wrValid`, `wrPtr` and `wrDelay` at index `wrAddr` of the idle bank only. It never changes the slot outputs before the next bank swap.
- R6: Each change of `swapToggle`, whether rising or falling, is one request. `swapTarget` is sampled on the third rising clock edge after the change. The swap can take place at a period boundary on the fourth edge or any later edge.
- R7: When a request is armed and the period that is ending has the code `swapTarget`, `activeBank` inverts on the edge that ends that period. The first slot after that edge reads from the new bank. The armed request is then consumed.
- R8: `lenWe` stores `lenLast`, the last slot index of the next schedule. That value becomes the wrap point on the swap edge. It has no effect on the wrap point before the swap.
- R9: The period code is one-hot over PERIODS bits. It rotates one position toward the MSB at every wrap, so a target of bit k matches every PERIODS-th period.
- R10: A new request that arrives while one is armed replaces the armed target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe into the idle bank |
| wrAddr | input | SLOT_W | Slot index written |
| wrValid | input | 1 | Valid flag to store |
| wrPtr | input | PTR_W | Transfer-table pointer to store |
| wrDelay | input | 2 | Postpone count (0..2) to store |
| lenWe | input | 1 | Load strobe for the next schedule's last slot |
| lenLast | input | SLOT_W | Last slot index of the next schedule |
| swapToggle | input | 1 | Two-phase swap request from another timing area |
| swapTarget | input | PERIODS | One-hot period at whose end the swap occurs |
| slotStart | output | 1 | High in the first cycle of each slot |
| curSlot | output | SLOT_W | Current slot index |
| slotValid | output | 1 | Valid flag of the current entry |
| slotPtr | output | PTR_W | Pointer of the current entry |
| slotDelay | output | 2 | Postpone count of the current entry |
| activeBank | output | 1 | Bank currently read |

## Verification
A wrong period register or a dropped request shows up as `activeBank` flipping one or more whole periods late or early, or never flipping. The outputs can therefore look correct for up to PERIODS times the schedule length. A wrong wrap value shows on `curSlot` on the first boundary after the swap. A write that lands in the active bank changes `slotPtr` or `slotValid` as soon as `curSlot` reaches the written index. The bench compares every output in every cycle against a model built from the requirements, so each of these errors is caught in the cycle where it first becomes visible.

// File: rtl/slot_swap_pkg.sv
package slot_swap_pkg;
  // strobes from the sequencing control to the table datapath
  typedef struct packed {
    logic slotAdv;    // last cycle of a slot
    logic periodEnd;  // last cycle of the last slot of a period
    logic bankFlip;   // swap the active bank on this edge
  } seqStrobe_t;

  localparam int DELAY_W = 2;
endpackage

// File: rtl/swap_seq_ctrl.sv
module swap_seq_ctrl
  import slot_swap_pkg::*;
#(
  parameter int SLOTS        = 8,
  parameter int PERIODS      = 4,
  parameter int CYC_PER_SLOT = 3,
  parameter int SYNC_STAGES  = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CYC_W  = (CYC_PER_SLOT > 1) ? $clog2(CYC_PER_SLOT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swapToggle,
  input  logic [PERIODS-1:0] swapTarget,
  input  logic               lenWe,
  input  logic [SLOT_W-1:0]  lenLast,
  output seqStrobe_t         strobe,
  output logic [SLOT_W-1:0]  slotIdx,
  output logic               slotStart
);
  localparam logic [CYC_W-1:0]  CYC_LAST   = CYC_W'(CYC_PER_SLOT - 1);
  localparam logic [SLOT_W-1:0] RESET_LAST = SLOT_W'(SLOTS - 1);

  logic [CYC_W-1:0]    cycQ;
  logic [SLOT_W-1:0]   slotQ;
  logic [SLOT_W-1:0]   lastQ;
  logic [SLOT_W-1:0]   pendLastQ;
  logic [PERIODS-1:0]  periodQ;
  logic [PERIODS-1:0]  targetQ;
  logic                armedQ;
  logic [SYNC_STAGES:0] syncQ;   // synchronizer plus one stage for edge detect
  logic                cmdEdge;

  assign cmdEdge = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  always_comb begin
    strobe.slotAdv   = (cycQ == CYC_LAST);
    strobe.periodEnd = strobe.slotAdv && (slotQ == lastQ);
    strobe.bankFlip  = strobe.periodEnd && armedQ && (periodQ == targetQ);
  end

  // toggle synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], swapToggle};
  end

  // cycle, slot and period counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycQ    <= '0;
      slotQ   <= '0;
      periodQ <= PERIODS'(1);
    end else begin
      cycQ <= strobe.slotAdv ? '0 : cycQ + 1'b1;
      if (strobe.periodEnd) begin
        slotQ   <= '0;
        periodQ <= {periodQ[PERIODS-2:0], periodQ[PERIODS-1]};
      end else if (strobe.slotAdv) begin
        slotQ <= slotQ + 1'b1;
      end
    end
  end

  // schedule length: pending value adopted at the swap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastQ     <= RESET_LAST;
      pendLastQ <= RESET_LAST;
    end else begin
      if (lenWe)           pendLastQ <= lenLast;
      if (strobe.bankFlip) lastQ     <= pendLastQ;
    end
  end

  // request capture; bundled target is stable once the edge is seen
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ  <= 1'b0;
      targetQ <= '0;
    end else if (cmdEdge) begin
      armedQ  <= 1'b1;
      targetQ <= swapTarget;
    end else if (strobe.bankFlip) begin
      armedQ  <= 1'b0;
    end
  end

  assign slotIdx   = slotQ;
  assign slotStart = (cycQ == '0);
endmodule

// File: rtl/swap_slot_bank.sv
module swap_slot_bank
  import slot_swap_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int PTR_W = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [SLOT_W-1:0]  slotIdx,
  input  logic               wrEn,
  input  logic [SLOT_W-1:0]  wrAddr,
  input  logic               wrValid,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [DELAY_W-1:0] wrDelay,
  output logic               rdValid,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [DELAY_W-1:0] rdDelay,
  output logic               bankSel
);
  logic               vldMem [2][SLOTS];
  logic [PTR_W-1:0]   ptrMem [2][SLOTS];
  logic [DELAY_W-1:0] dlyMem [2][SLOTS];
  logic               bankQ;
  logic               idleBank;

  assign idleBank = ~bankQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        for (int s = 0; s < SLOTS; s++) begin
          vldMem[b][s] <= 1'b0;
          ptrMem[b][s] <= '0;
          dlyMem[b][s] <= '0;
        end
      end
    end else begin
      if (wrEn) begin
        vldMem[idleBank][wrAddr] <= wrValid;
        ptrMem[idleBank][wrAddr] <= wrPtr;
        dlyMem[idleBank][wrAddr] <= wrDelay;
      end
      if (strobe.bankFlip) bankQ <= ~bankQ;
    end
  end

  assign rdValid = vldMem[bankQ][slotIdx];
  assign rdPtr   = ptrMem[bankQ][slotIdx];
  assign rdDelay = dlyMem[bankQ][slotIdx];
  assign bankSel = bankQ;
endmodule

// File: rtl/slot_swap_unit.sv
module slot_swap_unit
  import slot_swap_pkg::*;
#(
  parameter int SLOTS        = 8,
  parameter int PERIODS      = 4,
  parameter int CYC_PER_SLOT = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int PTR_W        = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [SLOT_W-1:0]  wrAddr,
  input  logic               wrValid,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [1:0]         wrDelay,
  input  logic               lenWe,
  input  logic [SLOT_W-1:0]  lenLast,
  input  logic               swapToggle,
  input  logic [PERIODS-1:0] swapTarget,
  output logic               slotStart,
  output logic [SLOT_W-1:0]  curSlot,
  output logic               slotValid,
  output logic [PTR_W-1:0]   slotPtr,
  output logic [1:0]         slotDelay,
  output logic               activeBank
);
  seqStrobe_t        seqStb;
  logic [SLOT_W-1:0] slotIdx;

  swap_seq_ctrl #(
    .SLOTS(SLOTS), .PERIODS(PERIODS),
    .CYC_PER_SLOT(CYC_PER_SLOT), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .swapToggle(swapToggle), .swapTarget(swapTarget),
    .lenWe(lenWe), .lenLast(lenLast),
    .strobe(seqStb), .slotIdx(slotIdx), .slotStart(slotStart)
  );

  swap_slot_bank #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rstN(rstN),
    .strobe(seqStb), .slotIdx(slotIdx),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrValid(wrValid),
    .wrPtr(wrPtr), .wrDelay(wrDelay),
    .rdValid(slotValid), .rdPtr(slotPtr), .rdDelay(slotDelay),
    .bankSel(activeBank)
  );

  assign curSlot = slotIdx;
endmodule

// File: rtl/slot_swap_unit_chk.sv
module slot_swap_unit_chk
  import slot_swap_pkg::*;
#(
  parameter int SLOTS        = 8,
  parameter int CYC_PER_SLOT = 3,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              slotStart,
  input logic [SLOT_W-1:0] curSlot,
  input logic              activeBank,
  input seqStrobe_t        seqStb
);
  int unsigned       gapCnt;
  logic              seenStart;
  logic [SLOT_W-1:0] prevSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= 0;
      seenStart <= 1'b0;
      prevSlot  <= '0;
    end else if (slotStart) begin
      gapCnt    <= 0;
      seenStart <= 1'b1;
      prevSlot  <= curSlot;
    end else begin
      gapCnt <= gapCnt + 1;
    end
  end

  // R2: slot starts are evenly spaced
  assert_start_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && seenStart) |-> (gapCnt == CYC_PER_SLOT - 1));

  // R3: slot index steps by one or wraps to zero
  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && seenStart) |-> (curSlot == prevSlot + 1'b1 || curSlot == '0));

  // R3: slot index moves only at a slot start
  assert_slot_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curSlot) |-> slotStart);

  // R7: bank changes only at the start of a period
  assert_flip_boundary_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeBank) |-> (slotStart && curSlot == '0));

  // R7: a flip strobe from control inverts the datapath bank
  assert_flip_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqStb.bankFlip |=> (activeBank != $past(activeBank)));

  // R7: a flip is only ever requested at a period end
  assert_flip_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqStb.bankFlip |-> seqStb.periodEnd);
endmodule

bind slot_swap_unit slot_swap_unit_chk #(
  .SLOTS(SLOTS), .CYC_PER_SLOT(CYC_PER_SLOT)
) u_chk (
  .clk(clk), .rstN(rstN), .slotStart(slotStart), .curSlot(curSlot),
  .activeBank(activeBank), .seqStb(seqStb)
);

// File: tb/slot_swap_unit_tb.sv
module slot_swap_unit_tb;
  localparam int SLOTS = 8;
  localparam int PERIODS = 4;
  localparam int PTR_W = 4;
  localparam int SLOT_W = 3;
  localparam int RUN_CYCLES = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [SLOT_W-1:0] wrAddr = '0;
  logic wrValid = 1'b0;
  logic [PTR_W-1:0] wrPtr = '0;
  logic [1:0] wrDelay = '0;
  logic lenWe = 1'b0;
  logic [SLOT_W-1:0] lenLast = '0;
  logic swapToggle = 1'b0;
  logic [PERIODS-1:0] swapTarget = '0;
  logic slotStart;
  logic [SLOT_W-1:0] curSlot;
  logic slotValid;
  logic [PTR_W-1:0] slotPtr;
  logic [1:0] slotDelay;
  logic activeBank;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  slot_swap_unit u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrValid(wrValid),
    .wrPtr(wrPtr), .wrDelay(wrDelay), .lenWe(lenWe), .lenLast(lenLast),
    .swapToggle(swapToggle), .swapTarget(swapTarget),
    .slotStart(slotStart), .curSlot(curSlot), .slotValid(slotValid),
    .slotPtr(slotPtr), .slotDelay(slotDelay), .activeBank(activeBank)
  );

  // requirement model state
  int mCyc, mSlot, mLast, mPend, mPer, mTgt, mBank;
  bit mArmed;
  bit tq0, tq1, tq2;
  bit mV [2][SLOTS];
  int mP [2][SLOTS];
  int mD [2][SLOTS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rotl(input int v);
    return ((v << 1) | (v >> (PERIODS - 1))) & ((1 << PERIODS) - 1);
  endfunction

  task automatic modelReset();
    mCyc = 0; mSlot = 0; mLast = SLOTS - 1; mPend = SLOTS - 1;
    mPer = 1; mTgt = 0; mBank = 0; mArmed = 0;
    tq0 = 0; tq1 = 0; tq2 = 0;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < SLOTS; s++) begin
        mV[b][s] = 0; mP[b][s] = 0; mD[b][s] = 0;
      end
  endtask

  // one rising edge with the inputs now driven
  task automatic modelStep();
    bit adv, pend, flip, edgeSeen;
    adv = (mCyc == 2);
    pend = adv && (mSlot == mLast);
    flip = pend && mArmed && (mPer == mTgt);
    if (wrEn) begin
      mV[1 - mBank][wrAddr] = wrValid;
      mP[1 - mBank][wrAddr] = wrPtr;
      mD[1 - mBank][wrAddr] = wrDelay;
    end
    edgeSeen = tq1 ^ tq2;
    if (edgeSeen) begin mArmed = 1; mTgt = swapTarget; end
    else if (flip) mArmed = 0;
    tq2 = tq1; tq1 = tq0; tq0 = swapToggle;
    if (flip) begin mLast = mPend; mBank = 1 - mBank; end
    if (lenWe) mPend = lenLast;
    mCyc = adv ? 0 : mCyc + 1;
    if (pend) begin mSlot = 0; mPer = rotl(mPer); end
    else if (adv) mSlot = mSlot + 1;
  endtask

  task automatic compareAll();
    chk(slotStart == (mCyc == 0), "R2 slotStart", slotStart, mCyc == 0);
    chk(curSlot == mSlot, "R3 R8 curSlot", curSlot, mSlot);
    chk(activeBank == mBank, "R6 R7 R9 R10 activeBank", activeBank, mBank);
    chk(slotValid == mV[mBank][mSlot], "R4 R5 slotValid", slotValid, mV[mBank][mSlot]);
    chk(slotPtr == mP[mBank][mSlot], "R4 R5 slotPtr", slotPtr, mP[mBank][mSlot]);
    chk(slotDelay == mD[mBank][mSlot], "R4 slotDelay", slotDelay, mD[mBank][mSlot]);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int cool;
    cool = 0;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (4) @(negedge clk);
    // R1: state while reset is held
    chk(activeBank == 0, "R1 bank in reset", activeBank, 0);
    chk(curSlot == 0, "R1 slot in reset", curSlot, 0);
    rstN = 1'b1;
    for (int n = 0; n < RUN_CYCLES; n++) begin
      if (n == 0) begin
        chk(slotStart == 1, "R1 slotStart", slotStart, 1);
        chk(slotValid == 0 && slotPtr == 0 && slotDelay == 0, "R1 entry", slotPtr, 0);
      end
      // directed: length 8 until the swap, then length 5 (R8, R9)
      if (n == 47) chk(activeBank == 0, "R8 R9 bank before target end", activeBank, 0);
      if (n == 48) chk(activeBank == 1 && curSlot == 0, "R7 R9 swap edge", activeBank, 1);
      if (n == 60) chk(curSlot == 4, "R8 new last slot", curSlot, 4);
      if (n == 63) chk(curSlot == 0, "R8 new wrap", curSlot, 0);
      compareAll();
      wrEn = 0; lenWe = 0;
      if (n < SLOTS) begin
        // R5: fill the idle bank; active outputs must stay cleared
        wrEn = 1; wrAddr = SLOT_W'(n); wrValid = 1;
        wrPtr = PTR_W'(n + 1); wrDelay = 2'(n % 3);
      end else if (n == 8) begin
        lenWe = 1; lenLast = 3'd4;
      end else if (n == 10) begin
        swapTarget = 4'b0010; swapToggle = ~swapToggle;  // R6
      end else if (n >= 200) begin
        if ($urandom % 4 == 0) begin
          wrEn = 1; wrAddr = SLOT_W'($urandom); wrValid = 1'($urandom);
          wrPtr = PTR_W'($urandom); wrDelay = 2'($urandom % 3);
        end
        if ($urandom % 40 == 0) begin
          lenWe = 1; lenLast = SLOT_W'($urandom);
        end
        if (cool > 0) cool--;
        else if ($urandom % 30 == 0) begin
          swapTarget = PERIODS'(1 << ($urandom % PERIODS));
          swapToggle = ~swapToggle;
          cool = 6;
        end
      end
      modelStep();
      @(posedge clk);
      @(negedge clk);
    end
    finish();
  end
endmodule